// File: doc/BRIEF.md
# ATA Device Task File Register Block

This block is the device-side register file of a parallel ATA disk controller as a host bus sees it. The host reaches it through two chip selects. The command-block select decodes eight byte offsets, and the control select decodes two offsets. Behind these sit a 16-bit data register, the error, sector count, sector number, cylinder and drive/head bytes, the status and command pair, a device control register and a read-only drive address byte. Reads and writes are single-cycle strobes, and read data is presented combinationally while the read strobe is high.

An internal command engine sits on the other side. It receives a one-cycle start pulse with the command code when the host writes the command offset. It reports back through status and error load strobes, an interrupt request pulse, a data load port and a "writing" flag. A small controller tracks three named states:
- READY: the host may write the task file.
- BUSY: the BSY bit is 1.
- SRST: a soft reset is held through device control.

Transitions:
- READY→BUSY happens on an accepted command write, or when the engine loads a status byte with BSY set.
- BUSY→READY happens when the engine loads a status byte with BSY clear.
- Any state goes to SRST on a device control write with the reset bit set.
- SRST→READY happens on a device control write with that bit clear.

Top module: `ata_taskfile_regs`

## Requirements
- R1: Command-block offsets are decoded as follows:
  - 0 is the 16-bit data register.
  - 2 is sector count, 3 is sector number, 4 is cylinder low and 5 is cylinder high.
  - 6 is drive/head.
  - 7 reads status and writes command.

  Byte registers read back their last host value with bits 15:8 of the read data zero. The data register round-trips all 16 bits.
- R2: Drive/head (offset 6) stores bit 6 (LBA mode), bit 4 (drive, 1 = slave) and bits 3:0 (head). Bits 7 and 5 always read 1.
- R3: Offset 1 reads the error register. A host write to offset 1 is ignored and leaves the error value unchanged.
- R4: A host write to offset 7 in READY does three things:
  - It raises `cmd_start` for exactly the next cycle, with `cmd_code` holding the written byte.
  - It sets status bit 7 (BSY).
  - It clears status bit 3 (DRQ) and status bit 0 (ERR).
- R5: While BSY is set, host writes to any command-block offset are discarded. Reads of any command-block offset return the status byte. A second command write raises no `cmd_start`.
- R6: An engine status load sets status bits 6:0 to the loaded value. Loading with bit 7 clear ends BUSY, after which offset reads return register contents again. Status layout is bit 7 BSY, 6 RDY, 5 write fault, 4 seek complete, 3 DRQ, 2 corrected, 1 index, 0 ERR.
- R7: Interrupt behaviour:
  - An engine interrupt pulse sets a pending flag, and `intrq` equals pending AND NOT device-control bit 1 (mask).
  - A status read at offset 7 clears pending, and so does an accepted command write.
  - An alternate status read (control offset 0) returns status without clearing pending.
  - A new request in the same cycle as a clear wins.
- R8: Device-control bit 2 (control offset 0, write) holds soft reset while 1. During that time:
  - `soft_rst` is 1, status reads 0x50 (RDY and seek complete only) and pending is cleared.
  - Command-block writes and engine loads are ignored.
  - Sector count and sector number are 1, and all other registers are 0.
- R9: Control offset 1 reads the drive address byte: bit 7 = 1, bit 6 = NOT `eng_writing`, bits 5:2 = ones' complement of the head, bits 1:0 = active-low drive selects (bit 0 low for drive 0, bit 1 low for drive 1). Host writes to it are ignored.
- R10: An engine error load sets the error register, read at offset 1.
- R11: After hardware reset, status is 0x50, sector count and number are 1, drive/head reads 0xA0, `intrq`, `cmd_start` and `soft_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| hb_cs_cmd | input | 1 | Command-block group select |
| hb_cs_ctl | input | 1 | Control group select |
| hb_addr | input | 3 | Register offset within the group |
| hb_rd | input | 1 | Host read strobe |
| hb_wr | input | 1 | Host write strobe |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data |
| intrq | output | 1 | Interrupt request to host |
| cmd_start | output | 1 | One-cycle command start to engine |
| cmd_code | output | 8 | Command register contents |
| soft_rst | output | 1 | Soft reset held to engine |
| eng_status_we | input | 1 | Engine status load |
| eng_status | input | 8 | Engine status value |
| eng_error_we | input | 1 | Engine error load |
| eng_error | input | 8 | Engine error value |
| eng_data_we | input | 1 | Engine data register load |
| eng_data | input | 16 | Engine data value |
| eng_irq | input | 1 | Engine interrupt request pulse |
| eng_writing | input | 1 | Engine is writing the medium |

## Verification
A controller stuck in the wrong state shows at the very next host read. A phantom BUSY makes every command-block offset return the status byte instead of its register. A missed SRST lets sector count keep a host value instead of 1. A pending flag that is wrong in either direction is visible on `intrq` in the cycle after the request or the status read, unless the mask bit hides it. The bench therefore toggles the mask to expose pending state that the mask holds back. Dropped or doubled command starts appear on `cmd_start` one cycle after the command write.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_SRST  = 2'd2
    } tf_state_e;

    // command-block offsets
    localparam int OFS_DATA  = 0;
    localparam int OFS_ERR   = 1;
    localparam int OFS_CNT   = 2;
    localparam int OFS_NUM   = 3;
    localparam int OFS_CYLLO = 4;
    localparam int OFS_CYLHI = 5;
    localparam int OFS_DH    = 6;
    localparam int OFS_STAT  = 7;

    // status and device-control bit positions
    localparam int SB_BSY  = 7;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;
    localparam int DC_SRST = 2;
    localparam int DC_NIEN = 1;

    localparam logic [7:0] STAT_RESET = 8'h50;

endpackage

// File: rtl/ata_tf_decode.sv
`timescale 1ns/1ps
module ata_tf_decode #(
    parameter int ADDR_W = 3,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              cs_cmd,
    input  logic              cs_ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [NREG-1:0]   cb_wr,
    output logic [NREG-1:0]   cb_rd,
    output logic              dc_wr,
    output logic              alt_rd,
    output logic              drv_rd
);
    logic ctl_sel;
    assign ctl_sel = cs_ctl & ~cs_cmd;

    for (genvar g = 0; g < NREG; g++) begin : g_cb
        assign cb_wr[g] = cs_cmd & wr & (addr == ADDR_W'(g));
        assign cb_rd[g] = cs_cmd & rd & (addr == ADDR_W'(g));
    end

    assign dc_wr  = ctl_sel & wr & ~addr[0];
    assign alt_rd = ctl_sel & rd & ~addr[0];
    assign drv_rd = ctl_sel & rd &  addr[0];
endmodule

// File: rtl/ata_tf_ctrl.sv
`timescale 1ns/1ps
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter int REG_W = 8,
    localparam int LO_W = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             dc_wr,
    input  logic             dc_srst_in,
    input  logic             dc_nien_in,
    input  logic             stat_rd,
    input  logic             eng_stat_we,
    input  logic [REG_W-1:0] eng_stat,
    input  logic             eng_irq,
    output tf_state_e        state_o,
    output logic [REG_W-1:0] stat_byte,
    output logic             intrq,
    output logic             nien,
    output logic             cmd_start
);
    tf_state_e        state_q, state_d;
    logic [LO_W-1:0]  stat_lo_q;
    logic             pend_q;
    logic             nien_q;
    logic             start_q;
    logic             cmd_accept;
    logic             in_srst;

    assign cmd_accept = cmd_wr && (state_q == ST_READY);
    assign in_srst    = (state_d == ST_SRST) || (state_q == ST_SRST);

    // next state
    always_comb begin
        state_d = state_q;
        if (dc_wr && dc_srst_in) begin
            state_d = ST_SRST;
        end else begin
            unique case (state_q)
                ST_READY: begin
                    if (cmd_wr)
                        state_d = ST_BUSY;
                    else if (eng_stat_we && eng_stat[SB_BSY])
                        state_d = ST_BUSY;
                end
                ST_BUSY: begin
                    if (eng_stat_we && !eng_stat[SB_BSY])
                        state_d = ST_READY;
                end
                ST_SRST: begin
                    if (dc_wr && !dc_srst_in)
                        state_d = ST_READY;
                end
                default: state_d = ST_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_lo_q <= STAT_RESET[LO_W-1:0];
            pend_q    <= 1'b0;
            nien_q    <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            start_q <= cmd_accept;
            if (dc_wr)
                nien_q <= dc_nien_in;

            if (in_srst) begin
                stat_lo_q <= STAT_RESET[LO_W-1:0];
            end else if (cmd_accept) begin
                stat_lo_q[SB_DRQ] <= 1'b0;
                stat_lo_q[SB_ERR] <= 1'b0;
            end else if (eng_stat_we) begin
                stat_lo_q <= eng_stat[LO_W-1:0];
            end

            if (in_srst)
                pend_q <= 1'b0;
            else if (eng_irq)
                pend_q <= 1'b1;
            else if (stat_rd || cmd_accept)
                pend_q <= 1'b0;
        end
    end

    assign state_o   = state_q;
    assign stat_byte = {state_q == ST_BUSY, stat_lo_q};
    assign intrq     = pend_q & ~nien_q;
    assign nien      = nien_q;
    assign cmd_start = start_q;
endmodule

// File: rtl/ata_tf_regs.sv
`timescale 1ns/1ps
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3,
    localparam int NREG  = 1 << ADDR_W,
    localparam int NMID  = OFS_CYLHI - OFS_CNT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   cb_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_ok,
    input  logic              sreset,
    input  logic              eng_err_we,
    input  logic [REG_W-1:0]  eng_err,
    input  logic              eng_data_we,
    input  logic [DATA_W-1:0] eng_data,
    input  logic              rd_cb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_alt,
    input  logic              rd_drv,
    input  logic [REG_W-1:0]  stat_byte,
    input  logic              busy,
    input  logic              eng_writing,
    output logic [DATA_W-1:0] rdata,
    output logic [REG_W-1:0]  cmd_code
);
    logic [DATA_W-1:0] data_q;
    logic [REG_W-1:0]  err_q;
    logic [REG_W-1:0]  mid_q [NMID];
    logic [5:0]        dh_q;     // {lba, drv, head[3:0]}
    logic [REG_W-1:0]  cmd_q;
    logic              unused_precomp;

    assign unused_precomp = cb_wr[OFS_ERR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= '0;
            for (int i = 0; i < NMID; i++)
                mid_q[i] <= (i < 2) ? REG_W'(1) : '0;
            dh_q   <= '0;
            cmd_q  <= '0;
        end else if (sreset) begin
            data_q <= '0;
            err_q  <= '0;
            for (int i = 0; i < NMID; i++)
                mid_q[i] <= (i < 2) ? REG_W'(1) : '0;
            dh_q   <= '0;
            cmd_q  <= '0;
        end else begin
            if (eng_data_we)
                data_q <= eng_data;
            else if (wr_ok && cb_wr[OFS_DATA])
                data_q <= wdata;
            if (eng_err_we)
                err_q <= eng_err;
            for (int i = 0; i < NMID; i++)
                if (wr_ok && cb_wr[OFS_CNT + i])
                    mid_q[i] <= wdata[REG_W-1:0];
            if (wr_ok && cb_wr[OFS_DH])
                dh_q <= {wdata[6], wdata[4:0]};
            if (wr_ok && cb_wr[OFS_STAT])
                cmd_q <= wdata[REG_W-1:0];
        end
    end

    logic [REG_W-1:0] dh_view;
    logic [REG_W-1:0] drv_view;
    assign dh_view  = {1'b1, dh_q[5], 1'b1, dh_q[4:0]};
    assign drv_view = {1'b1, ~eng_writing, ~dh_q[3:0], ~dh_q[4], dh_q[4]};

    always_comb begin
        rdata = '0;
        if (rd_drv) begin
            rdata = DATA_W'(drv_view);
        end else if (rd_alt) begin
            rdata = DATA_W'(stat_byte);
        end else if (rd_cb) begin
            if (busy) begin
                rdata = DATA_W'(stat_byte);
            end else begin
                unique case (int'(rd_addr))
                    OFS_DATA:  rdata = data_q;
                    OFS_ERR:   rdata = DATA_W'(err_q);
                    OFS_CNT:   rdata = DATA_W'(mid_q[0]);
                    OFS_NUM:   rdata = DATA_W'(mid_q[1]);
                    OFS_CYLLO: rdata = DATA_W'(mid_q[2]);
                    OFS_CYLHI: rdata = DATA_W'(mid_q[3]);
                    OFS_DH:    rdata = DATA_W'(dh_view);
                    OFS_STAT:  rdata = DATA_W'(stat_byte);
                    default:   rdata = '0;
                endcase
            end
        end
    end

    assign cmd_code = cmd_q;
endmodule

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 3,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_cs_cmd,
    input  logic              hb_cs_ctl,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic              hb_rd,
    input  logic              hb_wr,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              intrq,
    output logic              cmd_start,
    output logic [REG_W-1:0]  cmd_code,
    output logic              soft_rst,
    input  logic              eng_status_we,
    input  logic [REG_W-1:0]  eng_status,
    input  logic              eng_error_we,
    input  logic [REG_W-1:0]  eng_error,
    input  logic              eng_data_we,
    input  logic [DATA_W-1:0] eng_data,
    input  logic              eng_irq,
    input  logic              eng_writing
);
    logic [NREG-1:0]  cb_wr, cb_rd;
    logic             dc_wr, alt_rd, drv_rd;
    tf_state_e        state;
    logic [REG_W-1:0] stat_byte;
    logic             busy, nien, wr_ok;

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs_cmd (hb_cs_cmd),
        .cs_ctl (hb_cs_ctl),
        .addr   (hb_addr),
        .rd     (hb_rd),
        .wr     (hb_wr),
        .cb_wr  (cb_wr),
        .cb_rd  (cb_rd),
        .dc_wr  (dc_wr),
        .alt_rd (alt_rd),
        .drv_rd (drv_rd)
    );

    ata_tf_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cb_wr[OFS_STAT]),
        .dc_wr       (dc_wr),
        .dc_srst_in  (hb_wdata[DC_SRST]),
        .dc_nien_in  (hb_wdata[DC_NIEN]),
        .stat_rd     (cb_rd[OFS_STAT]),
        .eng_stat_we (eng_status_we),
        .eng_stat    (eng_status),
        .eng_irq     (eng_irq),
        .state_o     (state),
        .stat_byte   (stat_byte),
        .intrq       (intrq),
        .nien        (nien),
        .cmd_start   (cmd_start)
    );

    assign busy     = (state == ST_BUSY);
    assign soft_rst = (state == ST_SRST);
    assign wr_ok    = (state == ST_READY);

    ata_tf_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cb_wr       (cb_wr),
        .wdata       (hb_wdata),
        .wr_ok       (wr_ok),
        .sreset      (soft_rst),
        .eng_err_we  (eng_error_we),
        .eng_err     (eng_error),
        .eng_data_we (eng_data_we),
        .eng_data    (eng_data),
        .rd_cb       (|cb_rd),
        .rd_addr     (hb_addr),
        .rd_alt      (alt_rd),
        .rd_drv      (drv_rd),
        .stat_byte   (stat_byte),
        .busy        (busy),
        .eng_writing (eng_writing),
        .rdata       (hb_rdata),
        .cmd_code    (cmd_code)
    );
endmodule

// File: rtl/ata_tf_checker.sv
`timescale 1ns/1ps
module ata_tf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hb_cs_cmd,
    input logic       hb_cs_ctl,
    input logic [2:0] hb_addr,
    input logic       hb_rd,
    input logic       hb_wr,
    input logic       intrq,
    input logic       cmd_start,
    input logic [7:0] cmd_code,
    input logic       soft_rst,
    input logic [7:0] stat_byte,
    input logic       busy,
    input logic       nien,
    input logic       eng_irq
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R4
    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr && hb_cs_cmd && hb_addr == 3'd7 && !busy && !soft_rst) |=> (cmd_start && busy)); // R4
    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hb_wr && hb_cs_cmd) |=> $stable(cmd_code)); // R5
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_rd && hb_cs_cmd && hb_addr == 3'd7 && !eng_irq) |=> !intrq); // R7
    AST_ALT_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_rd && hb_cs_ctl && !hb_cs_cmd && !hb_addr[0] && !hb_wr && intrq) |=> intrq); // R7
    AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_irq && !soft_rst && !nien && !hb_wr) |=> intrq); // R7
    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !intrq); // R8
    AST_SRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (stat_byte == 8'h50)); // R8
endmodule

bind ata_taskfile_regs ata_tf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hb_cs_cmd (hb_cs_cmd),
    .hb_cs_ctl (hb_cs_ctl),
    .hb_addr   (hb_addr),
    .hb_rd     (hb_rd),
    .hb_wr     (hb_wr),
    .intrq     (intrq),
    .cmd_start (cmd_start),
    .cmd_code  (cmd_code),
    .soft_rst  (soft_rst),
    .stat_byte (stat_byte),
    .busy      (busy),
    .nien      (nien),
    .eng_irq   (eng_irq)
);

// File: tb/ata_taskfile_regs_bench.sv
`timescale 1ns/1ps
module ata_taskfile_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_cs_cmd = 1'b0, hb_cs_ctl = 1'b0;
    logic [2:0]  hb_addr = '0;
    logic        hb_rd = 1'b0, hb_wr = 1'b0;
    logic [15:0] hb_wdata = '0;
    logic [15:0] hb_rdata;
    logic        intrq, cmd_start, soft_rst;
    logic [7:0]  cmd_code;
    logic        eng_status_we = 1'b0, eng_error_we = 1'b0, eng_data_we = 1'b0;
    logic [7:0]  eng_status = '0, eng_error = '0;
    logic [15:0] eng_data = '0;
    logic        eng_irq = 1'b0, eng_writing = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ata_taskfile_regs u_ata_taskfile_regs (
        .clk(clk), .rst_n(rst_n), .hb_cs_cmd(hb_cs_cmd), .hb_cs_ctl(hb_cs_ctl),
        .hb_addr(hb_addr), .hb_rd(hb_rd), .hb_wr(hb_wr), .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata), .intrq(intrq), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .soft_rst(soft_rst), .eng_status_we(eng_status_we), .eng_status(eng_status),
        .eng_error_we(eng_error_we), .eng_error(eng_error), .eng_data_we(eng_data_we),
        .eng_data(eng_data), .eng_irq(eng_irq), .eng_writing(eng_writing)
    );

    function automatic logic [15:0] exp_dh(input logic [7:0] v);
        return {8'h00, 1'b1, v[6], 1'b1, v[4:0]};
    endfunction

    function automatic logic [15:0] exp_drv(input logic [7:0] dh, input logic wrt);
        return {8'h00, 1'b1, ~wrt, ~dh[3:0], ~dh[4], dh[4]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cb(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        hb_cs_cmd = 1'b1; hb_addr = a; hb_wdata = v; hb_wr = 1'b1;
        @(negedge clk);
        hb_cs_cmd = 1'b0; hb_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        hb_cs_ctl = 1'b1; hb_addr = a; hb_wdata = v; hb_wr = 1'b1;
        @(negedge clk);
        hb_cs_ctl = 1'b0; hb_wr = 1'b0;
    endtask

    task automatic rd_cb(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        hb_cs_cmd = 1'b1; hb_addr = a; hb_rd = 1'b1;
        #1 v = hb_rdata;
        @(negedge clk);
        hb_cs_cmd = 1'b0; hb_rd = 1'b0;
    endtask

    task automatic rd_ctl(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        hb_cs_ctl = 1'b1; hb_addr = a; hb_rd = 1'b1;
        #1 v = hb_rdata;
        @(negedge clk);
        hb_cs_ctl = 1'b0; hb_rd = 1'b0;
    endtask

    task automatic eng_stat(input logic [7:0] v);
        @(negedge clk); eng_status = v; eng_status_we = 1'b1;
        @(negedge clk); eng_status_we = 1'b0;
    endtask

    task automatic eng_err(input logic [7:0] v);
        @(negedge clk); eng_error = v; eng_error_we = 1'b1;
        @(negedge clk); eng_error_we = 1'b0;
    endtask

    task automatic eng_int();
        @(negedge clk); eng_irq = 1'b1;
        @(negedge clk); eng_irq = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        logic [15:0] m_data;
        logic [7:0]  m_byte [8];
        logic [7:0]  m_dh;
        void'($urandom(32'd5150));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd_ctl(3'd0, rv); chk("R11 status", rv, 16'h0050);
        rd_cb(3'd2, rv);  chk("R11 count", rv, 16'h0001);
        rd_cb(3'd3, rv);  chk("R11 number", rv, 16'h0001);
        rd_cb(3'd6, rv);  chk("R11 drive/head", rv, 16'h00A0);
        chk("R11 intrq", {15'd0, intrq}, 16'd0);
        chk("R11 cmd_start", {15'd0, cmd_start}, 16'd0);
        chk("R11 soft_rst", {15'd0, soft_rst}, 16'd0);

        // R1 and R2 random round trips
        m_data = 16'h0000; m_dh = 8'h00;
        for (int k = 0; k < 8; k++) m_byte[k] = (k == 2 || k == 3) ? 8'h01 : 8'h00;
        wr_cb(3'd0, 16'hBEEF); m_data = 16'hBEEF;
        rd_cb(3'd0, rv); chk("R1 data 16-bit", rv, 16'hBEEF);
        wr_cb(3'd6, 16'h004F); m_dh = 8'h4F;
        rd_cb(3'd6, rv); chk("R2 drive/head fixed ones", rv, 16'h00EF);
        for (int i = 0; i < 60; i++) begin
            int unsigned pick;
            logic [2:0] a;
            logic [15:0] v;
            logic [15:0] e;
            pick = $urandom % 6;
            a = (pick == 0) ? 3'd0 : 3'(pick + 1);
            v = 16'($urandom);
            wr_cb(a, v);
            if (a == 3'd0) m_data = v;
            else if (a == 3'd6) m_dh = v[7:0];
            else m_byte[a] = v[7:0];
            pick = $urandom % 6;
            a = (pick == 0) ? 3'd0 : 3'(pick + 1);
            rd_cb(a, rv);
            if (a == 3'd0) e = m_data;
            else if (a == 3'd6) e = exp_dh(m_dh);
            else e = {8'h00, m_byte[a]};
            chk((a == 3'd6) ? "R2 random drive/head" : "R1 random offset", rv, e);
        end

        // R3 / R10 error register and precompensation
        eng_err(8'h5A);
        rd_cb(3'd1, rv); chk("R10 error load", rv, 16'h005A);
        wr_cb(3'd1, 16'h0033);
        rd_cb(3'd1, rv); chk("R3 precomp write ignored", rv, 16'h005A);

        // R9 drive address
        wr_cb(3'd6, 16'h0015); m_dh = 8'h15;
        rd_ctl(3'd1, rv); chk("R9 drive addr slave head5", rv, exp_drv(8'h15, 1'b0));
        eng_writing = 1'b1;
        rd_ctl(3'd1, rv); chk("R9 drive addr writing", rv, exp_drv(8'h15, 1'b1));
        eng_writing = 1'b0;
        wr_ctl(3'd1, 16'h0000);
        rd_ctl(3'd1, rv); chk("R9 drive addr write ignored", rv, exp_drv(8'h15, 1'b0));
        wr_cb(3'd6, 16'h0000); m_dh = 8'h00;
        rd_ctl(3'd1, rv); chk("R9 drive addr master head0", rv, 16'h00FE);

        // R4 command start
        wr_cb(3'd2, 16'h0042);
        eng_stat(8'h59);
        rd_ctl(3'd0, rv); chk("R6 status layout", rv, 16'h0059);
        wr_cb(3'd7, 16'h0020);
        chk("R4 cmd_start pulse", {15'd0, cmd_start}, 16'd1);
        chk("R4 cmd_code", {8'h00, cmd_code}, 16'h0020);
        @(negedge clk);
        chk("R4 cmd_start one cycle", {15'd0, cmd_start}, 16'd0);
        rd_ctl(3'd0, rv); chk("R4 BSY set DRQ ERR cleared", rv, 16'h00D0);

        // R5 busy behaviour
        rd_cb(3'd2, rv); chk("R5 read while busy gives status", rv, 16'h00D0);
        wr_cb(3'd2, 16'h0077);
        wr_cb(3'd7, 16'h00EC);
        chk("R5 no start while busy", {15'd0, cmd_start}, 16'd0);
        chk("R5 cmd_code kept", {8'h00, cmd_code}, 16'h0020);

        // R6 engine ends busy
        eng_stat(8'h58);
        rd_cb(3'd7, rv); chk("R6 status after engine load", rv, 16'h0058);
        rd_cb(3'd2, rv); chk("R5 write while busy discarded", rv, 16'h0042);

        // R7 interrupt
        eng_int();
        chk("R7 intrq raised", {15'd0, intrq}, 16'd1);
        rd_ctl(3'd0, rv);
        chk("R7 alt read keeps intrq", {15'd0, intrq}, 16'd1);
        wr_ctl(3'd0, 16'h0002);
        chk("R7 mask hides intrq", {15'd0, intrq}, 16'd0);
        wr_ctl(3'd0, 16'h0000);
        chk("R7 pending survives mask", {15'd0, intrq}, 16'd1);
        rd_cb(3'd7, rv);
        chk("R7 status read clears", {15'd0, intrq}, 16'd0);
        eng_int();
        wr_cb(3'd7, 16'h0030);
        chk("R7 command write clears", {15'd0, intrq}, 16'd0);

        // R8 soft reset while busy
        wr_ctl(3'd0, 16'h0004);
        chk("R8 soft_rst high", {15'd0, soft_rst}, 16'd1);
        rd_ctl(3'd0, rv); chk("R8 status in reset", rv, 16'h0050);
        wr_cb(3'd3, 16'h0099);
        eng_int();
        chk("R8 irq ignored in reset", {15'd0, intrq}, 16'd0);
        wr_ctl(3'd0, 16'h0000);
        chk("R8 soft_rst released", {15'd0, soft_rst}, 16'd0);
        rd_cb(3'd2, rv); chk("R8 count reloaded", rv, 16'h0001);
        rd_cb(3'd3, rv); chk("R8 number reloaded", rv, 16'h0001);
        rd_cb(3'd1, rv); chk("R8 error cleared", rv, 16'h0000);
        rd_cb(3'd7, rv); chk("R8 status after release", rv, 16'h0050);

        finish_run();
    end
endmodule